// File: doc/BRIEF.md
# Page Descriptor Access/Dirty Updater

This block sits on the translation path and keeps the accessed and dirty status bits of a 64-bit page descriptor current. For each request it receives the descriptor's address, the descriptor value already fetched by the walker, a write flag and a 2-bit per-device tracking mode. Every request carries read intent. A request whose write flag is set also carries write intent. The block decides whether the status bits must change. If they must, it takes a lock on a simple 64-bit memory port and reads the descriptor again. It writes the descriptor back only if the fresh copy still needs marking, and then drops the lock.

The result is a one-cycle pulse on one of three outputs. The first lets the request continue. The second reports a descriptor that is not present. The third reports a descriptor address that is not 64-bit aligned. The block accepts a new request through a valid/ready handshake, and only while it is idle.

Top module: `pte_ad_updater`

## Requirements
- R1: After reset, `req_ready` is 1 and `mem_lock`, `mem_rd`, `mem_wr`, `done_o`, `fault_o` and `misalign_o` are all 0.
- R2: An accepted request whose address has any of bits [2:0] set pulses `misalign_o` in the cycle after acceptance and performs no memory access. This check has priority over all others.
- R3: An aligned request whose descriptor has the present bit (bit 0) clear pulses `fault_o` in the cycle after acceptance and performs no memory access.
- R4: Tracking modes 2'b00 and 2'b10 disable marking. A present, aligned request then pulses `done_o` in the cycle after acceptance, with no memory access, whatever the state of the status bits.
- R5: In mode 2'b01 only the accessed bit (bit 5) is maintained. If it is clear, the descriptor is re-read and written back with bit 5 set, and the dirty bit (bit 6) is left as read, even for a write.
- R6: In mode 2'b11, a write whose descriptor lacks the dirty bit (bit 6) or the accessed bit causes a write-back with both bits 5 and 6 set. A read sets only bit 5.
- R7: A request whose fetched descriptor already holds every needed bit pulses `done_o` in the cycle after acceptance, with no memory access.
- R8: If the descriptor re-read under lock no longer needs marking, the lock is released without a write and `done_o` pulses.
- R9: The write-back goes to the request's address as one 64-bit word. Every bit other than bits 5 and 6 equals the value re-read under lock.
- R10: `mem_lock` is high from the start of the re-read through the acknowledge of the write. It falls in the same cycle that `done_o` pulses.
- R11: `req_ready` is low while a locked update is in progress. At most one result pulse is high in any cycle, and each pulse lasts one cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_valid | input | 1 | Request valid |
| req_ready | output | 1 | Block idle, request can be taken |
| req_addr | input | AW | Byte address of the descriptor |
| req_desc | input | 64 | Descriptor as fetched by the walker |
| req_write | input | 1 | Request carries write intent |
| track_mode | input | 2 | Per-device tracking mode |
| done_o | output | 1 | One-cycle pulse: continue the request |
| fault_o | output | 1 | One-cycle pulse: descriptor not present |
| misalign_o | output | 1 | One-cycle pulse: descriptor address misaligned |
| mem_lock | output | 1 | Memory lock held for the atomic sequence |
| mem_rd | output | 1 | 64-bit read request |
| mem_wr | output | 1 | 64-bit write request |
| mem_addr | output | AW | Memory address |
| mem_wdata | output | 64 | Write data |
| mem_rdata | input | 64 | Read data, valid with `mem_ack` |
| mem_ack | input | 1 | Memory access complete |

## Verification
The hardest case to reach is the skipped write. The walker's copy of the descriptor must show that marking is needed, while the copy in memory already holds the bits, as if another agent had set them in between. The bench reaches this case by loading its memory model with a descriptor that differs from the one on `req_desc`. It then checks that one locked read, no write and a `done_o` pulse follow. Every other write-back scenario uses a patterned descriptor, so that any disturbed bit outside 5 and 6 shows up in the written word.

// File: rtl/pte_ad_updater.sv
module pte_ad_updater #(
  parameter int AW    = 48,
  parameter int P_BIT = 0,
  parameter int A_BIT = 5,
  parameter int D_BIT = 6
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          req_valid,
  output logic          req_ready,
  input  logic [AW-1:0] req_addr,
  input  logic [63:0]   req_desc,
  input  logic          req_write,
  input  logic [1:0]    track_mode,
  output logic          done_o,
  output logic          fault_o,
  output logic          misalign_o,
  output logic          mem_lock,
  output logic          mem_rd,
  output logic          mem_wr,
  output logic [AW-1:0] mem_addr,
  output logic [63:0]   mem_wdata,
  input  logic [63:0]   mem_rdata,
  input  logic          mem_ack
);

  localparam logic [63:0] AD_MASK = (64'd1 << A_BIT) | (64'd1 << D_BIT);

  typedef enum logic [1:0] {S_IDLE, S_RD, S_WR} state_t;

  state_t        st;
  logic [AW-1:0] addr_q;
  logic          wr_q, dmode_q;
  logic [63:0]   wdata_q;

  function automatic logic needs_mark(logic [63:0] d, logic wr, logic dm);
    return !d[A_BIT] || (wr && dm && !d[D_BIT]);
  endfunction

  function automatic logic [63:0] marked(logic [63:0] d, logic wr, logic dm);
    logic [63:0] r;
    r = d;
    r[A_BIT] = 1'b1;
    if (wr && dm) r[D_BIT] = 1'b1;
    return r;
  endfunction

  wire accept   = req_valid && req_ready;
  wire tracking = track_mode[0];
  wire dirty_on = &track_mode;
  wire misalign = |req_addr[2:0];

  assign req_ready = (st == S_IDLE);
  assign mem_lock  = (st != S_IDLE);
  assign mem_rd    = (st == S_RD);
  assign mem_wr    = (st == S_WR);
  assign mem_addr  = addr_q;
  assign mem_wdata = wdata_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st         <= S_IDLE;
      addr_q     <= '0;
      wr_q       <= 1'b0;
      dmode_q    <= 1'b0;
      wdata_q    <= '0;
      done_o     <= 1'b0;
      fault_o    <= 1'b0;
      misalign_o <= 1'b0;
    end else begin
      done_o     <= 1'b0;
      fault_o    <= 1'b0;
      misalign_o <= 1'b0;
      case (st)
        S_IDLE: if (accept) begin
          if (misalign)              misalign_o <= 1'b1;
          else if (!req_desc[P_BIT]) fault_o    <= 1'b1;
          else if (tracking && needs_mark(req_desc, req_write, dirty_on)) begin
            st      <= S_RD;
            addr_q  <= req_addr;
            wr_q    <= req_write;
            dmode_q <= dirty_on;
          end else done_o <= 1'b1;
        end
        S_RD: if (mem_ack) begin
          if (needs_mark(mem_rdata, wr_q, dmode_q)) begin
            wdata_q <= marked(mem_rdata, wr_q, dmode_q);
            st      <= S_WR;
          end else begin
            st     <= S_IDLE;
            done_o <= 1'b1;
          end
        end
        S_WR: if (mem_ack) begin
          st     <= S_IDLE;
          done_o <= 1'b1;
        end
        default: st <= S_IDLE;
      endcase
    end
  end

  logic [63:0] seen_q;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) seen_q <= '0;
    else if (mem_rd && mem_ack) seen_q <= mem_rdata;
  end

  assert_one_result_R11: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({done_o, fault_o, misalign_o}));
  assert_aligned_access_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_rd || mem_wr) |-> (mem_addr[2:0] == 3'd0));
  assert_write_follows_read_R10: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(mem_wr) |-> $past(mem_rd && mem_ack && mem_lock));
  assert_release_with_done_R10: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(mem_lock) |-> ($past(mem_ack) && done_o));
  assert_keep_other_bits_R9: assert property (@(posedge clk) disable iff (!rst_n)
    mem_wr |-> ((((mem_wdata ^ seen_q) & ~AD_MASK) == 64'd0) && mem_wdata[A_BIT]));
  assert_fault_unlocked_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (fault_o || misalign_o) |-> !mem_lock);

endmodule

// File: tb/pte_ad_updater_test.sv
module pte_ad_updater_test;
  localparam int AW = 48;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          req_valid = 1'b0;
  logic          req_ready;
  logic [AW-1:0] req_addr = '0;
  logic [63:0]   req_desc = '0;
  logic          req_write = 1'b0;
  logic [1:0]    track_mode = 2'b00;
  logic          done_o, fault_o, misalign_o;
  logic          mem_lock, mem_rd, mem_wr;
  logic [AW-1:0] mem_addr;
  logic [63:0]   mem_wdata;
  logic [63:0]   mem_rdata = '0;
  logic          mem_ack = 1'b0;

  pte_ad_updater #(.AW(AW)) uut (.*);

  always #5 clk = ~clk;

  int total = 0, bad = 0, cycles = 0;
  logic [63:0]   mem_word;
  logic [63:0]   last_wdata;
  logic [AW-1:0] last_waddr;
  int rd_n, wr_n, nolock_n, wcnt;
  int kind;
  int ready_busy;
  int width_bad;
  int lock_at_pulse;

  always @(negedge clk) begin
    if (mem_ack) begin
      mem_ack = 1'b0;
      wcnt = 0;
    end else if (mem_rd || mem_wr) begin
      if (!mem_lock) nolock_n++;
      if (wcnt == 1) begin
        mem_ack = 1'b1;
        wcnt = 0;
        if (mem_wr) begin
          mem_word   = mem_wdata;
          last_wdata = mem_wdata;
          last_waddr = mem_addr;
          wr_n++;
        end else begin
          mem_rdata = mem_word;
          rd_n++;
        end
      end else wcnt++;
    end
  end

  always @(posedge clk) begin
    cycles++;
    if (cycles > 20000) begin
      bad++; total++;
      $display("FAIL watchdog: act=%0d cycles exp<=20000", cycles);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  task automatic chk(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s: act=%h exp=%h", tag, act, exp);
    end
  endtask

  // kind: 0 none, 1 done, 2 fault, 3 misalign
  task automatic run(input logic [AW-1:0] a, input logic [63:0] d, input logic w,
                     input logic [1:0] m, input logic [63:0] memv);
    int n;
    mem_word = memv; rd_n = 0; wr_n = 0; nolock_n = 0; wcnt = 0;
    kind = 0; ready_busy = 0; width_bad = 0; lock_at_pulse = 0;
    last_wdata = '0; last_waddr = '0;
    @(negedge clk);
    req_addr = a; req_desc = d; req_write = w; track_mode = m; req_valid = 1'b1;
    @(posedge clk);
    @(negedge clk);
    req_valid = 1'b0;
    n = 0;
    while (!(done_o || fault_o || misalign_o) && n < 60) begin
      if (mem_lock && req_ready) ready_busy++;
      @(negedge clk);
      n++;
    end
    kind = done_o ? 1 : fault_o ? 2 : misalign_o ? 3 : 0;
    lock_at_pulse = mem_lock;
    @(negedge clk);
    if (done_o || fault_o || misalign_o) width_bad = 1;
  endtask

  task automatic t_reset;
    chk(req_ready == 1'b1, "R1 ready", req_ready, 1);
    chk({mem_lock, mem_rd, mem_wr} == 3'b0, "R1 mem idle", {mem_lock, mem_rd, mem_wr}, 0);
    chk({done_o, fault_o, misalign_o} == 3'b0, "R1 pulses", {done_o, fault_o, misalign_o}, 0);
  endtask

  task automatic t_misalign;
    run(48'h1004, 64'h1, 1'b1, 2'b11, 64'h1);
    chk(kind == 3, "R2 misalign pulse", kind, 3);
    chk(rd_n + wr_n == 0, "R2 no access", rd_n + wr_n, 0);
    run(48'h1001, 64'h0, 1'b0, 2'b00, 64'h0);
    chk(kind == 3, "R2 priority over present", kind, 3);
  endtask

  task automatic t_not_present;
    run(48'h2000, 64'hFFFF_0000_0000_0060, 1'b1, 2'b11, 64'h0);
    chk(kind == 2, "R3 fault pulse", kind, 2);
    chk(rd_n + wr_n == 0, "R3 no access", rd_n + wr_n, 0);
  endtask

  task automatic t_mode_off;
    run(48'h3000, 64'h1, 1'b1, 2'b00, 64'h1);
    chk(kind == 1 && rd_n + wr_n == 0, "R4 mode 00 passthrough", {kind, rd_n + wr_n}, 1);
    run(48'h3008, 64'h1, 1'b1, 2'b10, 64'h1);
    chk(kind == 1 && rd_n + wr_n == 0, "R4 mode 10 passthrough", {kind, rd_n + wr_n}, 1);
  endtask

  task automatic t_access_only;
    logic [63:0] d = 64'hA5A5_F00D_1234_5681;
    run(48'h4010, d, 1'b1, 2'b01, d);
    chk(kind == 1, "R5 done", kind, 1);
    chk(rd_n == 1 && wr_n == 1, "R5 one read one write", {rd_n, wr_n}, {32'd1, 32'd1});
    chk(last_wdata == (d | 64'h20), "R5 only accessed set", last_wdata, d | 64'h20);
    chk(last_waddr == 48'h4010, "R9 write address", last_waddr, 48'h4010);
    chk(nolock_n == 0, "R10 lock during access", nolock_n, 0);
    chk(lock_at_pulse == 0, "R10 lock released at done", lock_at_pulse, 0);
    chk(ready_busy == 0, "R11 not ready while busy", ready_busy, 0);
    chk(width_bad == 0, "R11 single-cycle pulse", width_bad, 0);
  endtask

  task automatic t_dirty;
    logic [63:0] d = 64'h5A00_00C3_0000_0F21;
    run(48'h5000, d, 1'b1, 2'b11, d);
    chk(wr_n == 1 && last_wdata == (d | 64'h40), "R6 dirty set on write", last_wdata, d | 64'h40);
    chk(kind == 1, "R6 done", kind, 1);
    d = 64'h0000_0000_0000_0081;
    run(48'h5008, d, 1'b1, 2'b11, d);
    chk(last_wdata == (d | 64'h60), "R6 both set", last_wdata, d | 64'h60);
    run(48'h5010, d, 1'b0, 2'b11, d);
    chk(last_wdata == (d | 64'h20), "R6 read sets accessed only", last_wdata, d | 64'h20);
  endtask

  task automatic t_no_update;
    run(48'h6000, 64'h61, 1'b1, 2'b11, 64'h61);
    chk(kind == 1 && rd_n + wr_n == 0, "R7 write already marked", {kind, rd_n + wr_n}, 1);
    run(48'h6008, 64'h21, 1'b0, 2'b11, 64'h21);
    chk(kind == 1 && rd_n + wr_n == 0, "R7 read already accessed", {kind, rd_n + wr_n}, 1);
    run(48'h6010, 64'h21, 1'b1, 2'b01, 64'h21);
    chk(kind == 1 && rd_n + wr_n == 0, "R7 access-only write", {kind, rd_n + wr_n}, 1);
  endtask

  task automatic t_recheck;
    run(48'h7000, 64'h1, 1'b1, 2'b11, 64'h61);
    chk(kind == 1, "R8 done after skip", kind, 1);
    chk(rd_n == 1 && wr_n == 0, "R8 read without write", {rd_n, wr_n}, {32'd1, 32'd0});
    chk(lock_at_pulse == 0, "R8 lock released", lock_at_pulse, 0);
    run(48'h7008, 64'h1, 1'b1, 2'b11, 64'hDEAD_0000_0000_0023);
    chk(wr_n == 1 && last_wdata == 64'hDEAD_0000_0000_0063, "R9 uses re-read value",
        last_wdata, 64'hDEAD_0000_0000_0063);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    @(negedge clk);
    t_misalign();
    t_not_present();
    t_mode_off();
    t_access_only();
    t_dirty();
    t_no_update();
    t_recheck();
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule